// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block decides which of twelve interrupt sources a 16-bit embedded processor core services next. Internal sources are three timers, two DMA channels, a watchdog and a serial port. There are also five external level-sensitive request inputs. Every source has a fixed type code and a fixed priority level, and level 0 is the most urgent. The three timers share one level and one type code, with a fixed order among them. Several other sources share the least urgent level.

A request is granted only when all of the following hold: the global enable input is high, the source's mask bit is clear, and its level is strictly more urgent than every level already in service. A grant gives a one-cycle `grantValid` pulse. With it come the 8-bit type, the vector-table byte address (four times the type) and the winning source index. The core writes the mask through a load port. It ends each service routine with an end-of-interrupt pulse, which retires the most urgent level in service. No acknowledge output exists.

Top module: `nest_int_ctrl`

## Requirements
- R1: After reset no grant is issued, the mask is all clear, no level is in service, and `grantType`, `grantVector` and `grantSrc` read zero.
- R2: `srcReq` bit positions and their (type, level) are: bit 0 timer A, bit 1 timer B and bit 2 timer C (all 08h, level 2); bit 3 DMA A (0Ah, 3); bit 4 DMA B (0Bh, 4); bits 5 to 9 external inputs 0 to 4 (0Ch to 10h, levels 5 to 9); bit 10 watchdog (11h, 9); bit 11 serial port (14h, 9). On a grant, `grantVector` equals the type times four, and types 09h and 15h to 1Fh never appear.
- R3: When timer requests are pending together, they are granted in the order timer A, timer B, timer C. Each carries type 08h, and `grantSrc` (the bit index) tells them apart.
- R4: Among eligible requests, the most urgent level wins. Within level 9, external input 4 wins over the watchdog, and the watchdog wins over the serial port.
- R5: While `intEnable` is low no grant is issued. Latched internal requests are kept and are granted once it rises.
- R6: A source whose mask bit is set (mask bit i matches `srcReq` bit i) is never granted and does not hold off less urgent sources. Its latched request stays pending and is granted after the bit is cleared.
- R7: A request is granted only if its level is strictly more urgent than the most urgent level in service. A request at an equal or less urgent level waits.
- R8: An `eoi` pulse retires only the most urgent level in service. Less urgent levels remain in service and keep holding off requests below them.
- R9: External inputs (bits 5 to 9) are not latched. A level that drops before it is granted leaves no request behind.
- R10: A request present at clock edge N is reported with `grantValid` high after edge N+1, provided it is eligible at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intEnable | input | 1 | Global interrupt enable from the core |
| srcReq | input | 12 | Request inputs: pulses from internal sources, held levels from external inputs |
| maskWr | input | 1 | Load strobe for the mask register |
| maskData | input | 12 | New mask value, bit i masks source i |
| eoi | input | 1 | End-of-interrupt pulse |
| grantValid | output | 1 | One-cycle grant indication |
| grantType | output | 8 | Type code of the last grant |
| grantVector | output | 10 | Vector-table byte address of the last grant |
| grantSrc | output | 4 | Source index of the last grant |

## Verification
A single request is applied from each source in turn. This separates the twelve type and vector entries and shows where the timers, which share type 08h, differ only in source index. Simultaneous requests are then applied: the three timers together and the three level-9 sources together. These show the fixed orders inside a shared level. Nested sequences raise a more urgent request, an equal one and a less urgent one while a level is in service. Together with single `eoi` pulses, they tell strict-urgency nesting apart from plain arbitration, and retiring only the top level apart from clearing everything. Patterns with the enable low, with a mask bit set, and with an external level dropped early show the difference between requests that are held and requests that are lost.

// File: rtl/nest_int_pkg.sv
package nest_int_pkg;
  localparam int NUM_SRC = 12;
  localparam int NUM_LVL = 10;
  localparam int TYPE_W  = 8;
  localparam int VEC_W   = TYPE_W + 2;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  localparam int EXT_LO  = 5;
  localparam int EXT_HI  = 9;

  // sources fed by held external levels rather than internal pulses
  localparam logic [NUM_SRC-1:0] LEVEL_SRC_MASK =
    NUM_SRC'(((1 << (EXT_HI + 1)) - 1) & ~((1 << EXT_LO) - 1));

  typedef struct packed {
    logic               grant;
    logic [SRC_W-1:0]   idx;
    logic [NUM_LVL-1:0] svcSet;
    logic [NUM_LVL-1:0] svcClr;
  } strobe_t;

  function automatic logic [TYPE_W-1:0] srcType(input logic [SRC_W-1:0] i);
    case (i)
      4'd0, 4'd1, 4'd2: srcType = 8'h08;
      4'd3:             srcType = 8'h0A;
      4'd4:             srcType = 8'h0B;
      4'd10:            srcType = 8'h11;
      4'd11:            srcType = 8'h14;
      default:          srcType = TYPE_W'(i) + 8'h07;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] srcLevel(input logic [SRC_W-1:0] i);
    case (i)
      4'd0, 4'd1, 4'd2: srcLevel = 4'd2;
      4'd10, 4'd11:     srcLevel = 4'd9;
      default:          srcLevel = LVL_W'(i);
    endcase
  endfunction
endpackage

// File: rtl/nest_int_ctl.sv
module nest_int_ctl
  import nest_int_pkg::*;
(
  input  logic               intEnable,
  input  logic               eoi,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [NUM_LVL-1:0] inSvc,
  output strobe_t            st
);
  logic [NUM_SRC-1:0] eligible;
  logic               winFound;
  logic [SRC_W-1:0]   winIdx;
  logic [LVL_W-1:0]   winLevel;
  logic [LVL_W-1:0]   hiSvc;
  logic               svcBusy;

  always_comb begin
    eligible = pending & ~maskQ;
    winFound = 1'b0;
    winIdx   = '0;
    // lowest index is most urgent; scan downward so it is taken last
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winFound = 1'b1;
        winIdx   = SRC_W'(i);
      end
    end
    hiSvc = LVL_W'(NUM_LVL);
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (inSvc[l]) hiSvc = LVL_W'(l);
    end
    svcBusy  = (hiSvc < LVL_W'(NUM_LVL));
    winLevel = srcLevel(winIdx);

    st.grant  = intEnable && winFound && (winLevel < hiSvc);
    st.idx    = winIdx;
    st.svcSet = st.grant ? (NUM_LVL'(1) << winLevel) : '0;
    st.svcClr = (eoi && svcBusy) ? (NUM_LVL'(1) << hiSvc) : '0;
  end
endmodule

// File: rtl/nest_int_dp.sv
module nest_int_dp
  import nest_int_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               maskWr,
  input  logic [NUM_SRC-1:0] maskData,
  input  strobe_t            st,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_LVL-1:0] inSvc,
  output logic               grantValid,
  output logic [TYPE_W-1:0]  grantType,
  output logic [VEC_W-1:0]   grantVector,
  output logic [SRC_W-1:0]   grantSrc
);
  logic [NUM_SRC-1:0] reqLatch;
  logic [NUM_SRC-1:0] extSample;
  logic [NUM_SRC-1:0] grantClr;
  logic [TYPE_W-1:0]  nextType;

  assign grantClr = st.grant ? (NUM_SRC'(1) << st.idx) : '0;
  assign pending  = reqLatch | extSample;
  assign nextType = srcType(st.idx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqLatch    <= '0;
      extSample   <= '0;
      maskQ       <= '0;
      inSvc       <= '0;
      grantValid  <= 1'b0;
      grantType   <= '0;
      grantVector <= '0;
      grantSrc    <= '0;
    end else begin
      // a fresh pulse in the grant cycle survives the clear
      reqLatch   <= (reqLatch & ~grantClr) | (srcReq & ~LEVEL_SRC_MASK);
      extSample  <= srcReq & LEVEL_SRC_MASK;
      inSvc      <= (inSvc & ~st.svcClr) | st.svcSet;
      grantValid <= st.grant;
      if (maskWr) maskQ <= maskData;
      if (st.grant) begin
        grantType   <= nextType;
        grantVector <= {nextType, 2'b00};
        grantSrc    <= st.idx;
      end
    end
  end
endmodule

// File: rtl/nest_int_ctrl.sv
module nest_int_ctrl
  import nest_int_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               intEnable,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               maskWr,
  input  logic [NUM_SRC-1:0] maskData,
  input  logic               eoi,
  output logic               grantValid,
  output logic [TYPE_W-1:0]  grantType,
  output logic [VEC_W-1:0]   grantVector,
  output logic [SRC_W-1:0]   grantSrc
);
  strobe_t            st;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_LVL-1:0] inSvc;

  nest_int_ctl ctl_i (
    .intEnable(intEnable),
    .eoi      (eoi),
    .pending  (pending),
    .maskQ    (maskQ),
    .inSvc    (inSvc),
    .st       (st)
  );

  nest_int_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .srcReq     (srcReq),
    .maskWr     (maskWr),
    .maskData   (maskData),
    .st         (st),
    .pending    (pending),
    .maskQ      (maskQ),
    .inSvc      (inSvc),
    .grantValid (grantValid),
    .grantType  (grantType),
    .grantVector(grantVector),
    .grantSrc   (grantSrc)
  );
endmodule

// File: rtl/nest_int_chk.sv
module nest_int_chk
  import nest_int_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               intEnable,
  input logic               eoi,
  input logic               grantValid,
  input logic [TYPE_W-1:0]  grantType,
  input logic [VEC_W-1:0]   grantVector,
  input logic [SRC_W-1:0]   grantSrc,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_LVL-1:0] inSvc
);
  logic [NUM_SRC-1:0] maskPrev;
  logic [NUM_LVL-1:0] svcPrev;
  logic               eoiPrev;
  logic [NUM_LVL-1:0] upToLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskPrev <= '0;
      svcPrev  <= '0;
      eoiPrev  <= 1'b0;
    end else begin
      maskPrev <= maskQ;
      svcPrev  <= inSvc;
      eoiPrev  <= eoi;
    end
  end

  assign upToLevel = NUM_LVL'((1 << (srcLevel(grantSrc) + 1)) - 1);

  // R2: vector is four times the type, and reserved types never leave
  p_vector_r2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantVector == {grantType, 2'b00}) && (grantType != 8'h09)
                   && !(grantType >= 8'h15 && grantType <= 8'h1F));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(intEnable) |-> !grantValid);

  p_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> !maskPrev[grantSrc]);

  p_nesting_r7: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((svcPrev & upToLevel) == '0));

  p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eoiPrev && svcPrev != '0 && !grantValid) |->
      ($countones(inSvc) + 1 == $countones(svcPrev)) && ((inSvc & ~svcPrev) == '0));
endmodule

bind nest_int_ctrl nest_int_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .intEnable  (intEnable),
  .eoi        (eoi),
  .grantValid (grantValid),
  .grantType  (grantType),
  .grantVector(grantVector),
  .grantSrc   (grantSrc),
  .maskQ      (maskQ),
  .inSvc      (inSvc)
);

// File: tb/nest_int_ctrl_tb_top.sv
module nest_int_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intEnable = 1'b0;
  logic [11:0] srcReq = '0;
  logic        maskWr = 1'b0;
  logic [11:0] maskData = '0;
  logic        eoi = 1'b0;
  logic        grantValid;
  logic [7:0]  grantType;
  logic [9:0]  grantVector;
  logic [3:0]  grantSrc;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [3:0] gSrc;
  logic [7:0] gType;
  logic [9:0] gVec;
  bit         got;

  always #2.5 clk = ~clk;

  nest_int_ctrl dut_i (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .srcReq(srcReq),
    .maskWr(maskWr), .maskData(maskData), .eoi(eoi),
    .grantValid(grantValid), .grantType(grantType),
    .grantVector(grantVector), .grantSrc(grantSrc)
  );

  // source index, type, vector address
  localparam logic [21:0] TBL [12] = '{
    {4'd0,  8'h08, 10'h020}, {4'd1,  8'h08, 10'h020}, {4'd2,  8'h08, 10'h020},
    {4'd3,  8'h0A, 10'h028}, {4'd4,  8'h0B, 10'h02C}, {4'd5,  8'h0C, 10'h030},
    {4'd6,  8'h0D, 10'h034}, {4'd7,  8'h0E, 10'h038}, {4'd8,  8'h0F, 10'h03C},
    {4'd9,  8'h10, 10'h040}, {4'd10, 8'h11, 10'h044}, {4'd11, 8'h14, 10'h050}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitGrant(input int maxCyc);
    got = 1'b0;
    for (int c = 0; c < maxCyc && !got; c++) begin
      @(negedge clk);
      if (grantValid) begin
        got = 1'b1; gSrc = grantSrc; gType = grantType; gVec = grantVector;
      end
    end
  endtask

  task automatic noGrantFor(input int n, input string req);
    bit seen = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (grantValid) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  task automatic pulse(input logic [11:0] bits);
    @(negedge clk); srcReq = bits;
    @(negedge clk); srcReq = srcReq & 12'h3E0;
  endtask

  task automatic endInt();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic expectSrc(input int src, input string req);
    waitGrant(6);
    check(got && gSrc == 4'(src), req, got ? int'(gSrc) : -1, src);
  endtask

  task automatic setMask(input logic [11:0] m);
    @(negedge clk); maskWr = 1'b1; maskData = m;
    @(negedge clk); maskWr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(grantValid == 1'b0, "R1", grantValid, 0);
    check(grantType == 8'h00 && grantVector == 10'h0 && grantSrc == 4'h0, "R1",
          {grantType, grantVector, grantSrc}, 0);
    intEnable = 1'b1;
    noGrantFor(3, "R1");

    // R2 table walk
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); srcReq = 12'(1) << TBL[k][21:18];
      @(negedge clk); srcReq = srcReq & 12'h3E0;
      waitGrant(4);
      srcReq = '0;
      check(got && gSrc == TBL[k][21:18], "R2", int'(gSrc), int'(TBL[k][21:18]));
      check(gType == TBL[k][17:10], "R2", gType, TBL[k][17:10]);
      check(gVec == TBL[k][9:0], "R2", gVec, TBL[k][9:0]);
      endInt();
    end

    // R10 latency
    @(negedge clk); srcReq = 12'h004;
    @(negedge clk); srcReq = '0;
    check(grantValid == 1'b0, "R10", grantValid, 0);
    @(negedge clk);
    check(grantValid == 1'b1 && grantSrc == 4'd2, "R10", {grantValid, grantSrc}, 5'h12);
    endInt();

    // R3 timer sub-order
    pulse(12'h007);
    expectSrc(0, "R3");
    check(gType == 8'h08, "R3", gType, 8'h08);
    endInt(); expectSrc(1, "R3");
    check(gType == 8'h08, "R3", gType, 8'h08);
    endInt(); expectSrc(2, "R3");
    endInt();

    // R4 urgency and level-9 tie order
    pulse(12'hE10);
    expectSrc(4, "R4");
    endInt(); expectSrc(9, "R4");
    srcReq = '0;
    endInt(); expectSrc(10, "R4");
    check(gType == 8'h11, "R4", gType, 8'h11);
    endInt(); expectSrc(11, "R4");
    endInt();

    // R7 / R8 nesting
    pulse(12'h010); expectSrc(4, "R7");
    pulse(12'h008); expectSrc(3, "R7");
    pulse(12'h008); noGrantFor(5, "R7");
    @(negedge clk); srcReq = 12'h020;
    endInt(); expectSrc(3, "R8");
    endInt(); noGrantFor(4, "R8");
    endInt(); expectSrc(5, "R8");
    srcReq = '0;
    endInt();
    pulse(12'h010); expectSrc(4, "R7");
    pulse(12'h800); noGrantFor(4, "R7");
    endInt(); expectSrc(11, "R7");
    endInt();

    // R5 global enable
    @(negedge clk); intEnable = 1'b0;
    pulse(12'h001); noGrantFor(5, "R5");
    @(negedge clk); intEnable = 1'b1;
    expectSrc(0, "R5");
    endInt();

    // R6 mask
    setMask(12'h008);
    pulse(12'h018); expectSrc(4, "R6");
    endInt(); noGrantFor(5, "R6");
    setMask(12'h000);
    expectSrc(3, "R6");
    endInt();

    // R9 external level dropped early
    @(negedge clk); intEnable = 1'b0; srcReq = 12'h040;
    repeat (3) @(negedge clk);
    srcReq = '0;
    repeat (2) @(negedge clk);
    intEnable = 1'b1;
    noGrantFor(5, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule